// File: doc/BRIEF.md
# S/PDIF Subframe Transmitter with Channel Status

This block turns parallel audio samples into a bi-phase-mark coded serial stream of the consumer digital audio format. Samples arrive as a left/right pair over a valid/ready handshake. Each frame holds two 32-slot subframes, and each slot is sent as two cells. One cell goes out per pulse of a 128×fs cell enable, so a subframe lasts 64 enable pulses. The block adds the preambles, the validity, user and channel status slots and an even parity slot. It also tracks the 192-frame status block.

Two 40-bit channel status words are held, one for each subframe. Both are replaced together by a single load strobe. In frame n of a block, the block sends bit n of the word for that subframe, and sends zero once n is past the end of the word. By default the validity slot comes from two control inputs, one per subframe. A per-sample mode instead takes the user, validity and status bits that come with each sample. A mute input forces the audio slots to zero. In single-channel double-rate mode, a pair is fetched before every subframe, and both subframes carry one chosen channel.

Top module: `spdif_tx`

## Requirements
- R1: During reset and until the first cell enable, `sdo`, `s_ready` and `underrun` are low.
- R2: A subframe is 64 cells. In normal mode subframe A carries the left sample and subframe B the right sample. Audio occupies slots 4..27, LSB first. A sample narrower than 24 bits is MSB-aligned so that its MSB sits in slot 27.
- R3: Preamble cells 0..7 are 11101000 (frame 0 of a block, subframe A), 11100010 (other subframe A) or 11100100 (subframe B), first cell leftmost. These values apply when the cell before the preamble is 0. When that cell is 1, every cell of the preamble is inverted.
- R4: For slots 4..31 the output toggles at the start of every slot, and toggles again at mid-slot when the slot value is 1.
- R5: Slot 31 makes the count of ones over slots 4..31 even.
- R6: A block is 192 frames. In frame n, slot 30 of subframe A carries bit n of `cs_a` and subframe B carries bit n of `cs_b` for n < 40. For n ≥ 40 it carries 0. `cs_load` replaces both words in one clock, and the new words take effect from the next subframe start.
- R7: With per-sample mode off, slot 28 of subframe A is `vld_a` and slot 28 of subframe B is `vld_b`, sampled at the subframe start. Slot 29 is 0.
- R8: With per-sample mode on, slots 28, 29 and 30 are the validity, user and status bits that arrived with the sample carried in that subframe.
- R9: With `mute` high at a subframe start, slots 4..27 are 0. Slots 28..31 and the preamble are formed as usual.
- R10: With `mono_en` high, a pair is fetched before every subframe. Both subframes carry the channel chosen by `mono_sel` (0 = left, 1 = right), together with that channel's per-sample bits.
- R11: `s_ready` is high only in a clock cycle where `cell_en` is high, the last cell of a subframe is being sent, and the next subframe needs a fetch. In normal mode the fetch happens only before subframe A. A transfer is `s_valid && s_ready`.
- R12: If `s_valid` is low at a fetch, the previously held sample and its bits are sent again. `underrun` then goes high and stays high until the next fetch that finds `s_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_en | input | 1 | Cell enable, 128 pulses per frame |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Sample pair taken this cycle |
| s_left | input | SAMPLE_W | Left sample |
| s_right | input | SAMPLE_W | Right sample |
| s_ubit_l | input | 1 | Per-sample user bit, left |
| s_vbit_l | input | 1 | Per-sample validity bit, left |
| s_cbit_l | input | 1 | Per-sample status bit, left |
| s_ubit_r | input | 1 | Per-sample user bit, right |
| s_vbit_r | input | 1 | Per-sample validity bit, right |
| s_cbit_r | input | 1 | Per-sample status bit, right |
| cs_load | input | 1 | Load both status words |
| cs_a | input | CS_BITS | Status word for subframe A |
| cs_b | input | CS_BITS | Status word for subframe B |
| vld_a | input | 1 | Validity for subframe A (per-sample mode off) |
| vld_b | input | 1 | Validity for subframe B (per-sample mode off) |
| per_sample | input | 1 | Take U/V/C from each sample |
| mute | input | 1 | Zero the audio slots |
| mono_en | input | 1 | Single-channel double-rate mode |
| mono_sel | input | 1 | Channel sent in that mode: 0 left, 1 right |
| sdo | output | 1 | Bi-phase-mark serial output |
| underrun | output | 1 | Last fetch found no sample |

## Verification
Several properties are checked on every cycle. The output holds steady between cell enables. Every stored subframe word has even parity. The frame index stays inside the block. The held sample changes only on a fetch, and the underrun flag rises only after a fetch that found no valid sample. The bench decodes the serial stream back into preambles and slots. Only that decoding can show the slot contents of each mode, the status bit positions across a whole block and its wrap, the preamble polarity choice, the muted audio and the replay after an underrun.

// File: rtl/spdif_tx_pkg.sv
`timescale 1ns/1ps
package spdif_tx_pkg;
    localparam int CELLS     = 64;
    localparam int CELL_W    = 6;
    localparam int AUDIO_W   = 24;
    localparam int PAYLOAD_W = 28;

    typedef enum logic [1:0] {PRE_B = 2'd0, PRE_M = 2'd1, PRE_W = 2'd2} pre_e;

    function automatic logic [7:0] pre_pattern(input pre_e p);
        case (p)
            PRE_B:   return 8'b1110_1000;
            PRE_M:   return 8'b1110_0010;
            default: return 8'b1110_0100;
        endcase
    endfunction
endpackage

// File: rtl/spdif_tx_seq.sv
`timescale 1ns/1ps
module spdif_tx_seq
    import spdif_tx_pkg::*;
#(
    parameter int BLOCK_FRAMES = 192,
    parameter int FW           = $clog2(BLOCK_FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_en,
    input  logic              mono_en,
    output logic [CELL_W-1:0] cnt,
    output logic              boundary,
    output logic              nxt_sub_b,
    output logic [FW-1:0]     nxt_frame,
    output logic              fetch
);
    typedef struct packed {
        logic [CELL_W-1:0] cnt;
        logic              sub_b;
        logic [FW-1:0]     frame;
    } seq_t;

    seq_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        boundary  = cell_en && (st_q.cnt == CELL_W'(CELLS - 1));
        nxt_sub_b = ~st_q.sub_b;
        nxt_frame = st_q.frame;
        if (!nxt_sub_b)
            nxt_frame = (st_q.frame == FW'(BLOCK_FRAMES - 1)) ? '0 : st_q.frame + 1'b1;
        fetch = boundary && (mono_en || !nxt_sub_b);
        if (cell_en)
            st_d.cnt = st_q.cnt + 1'b1;
        if (boundary) begin
            st_d.sub_b = nxt_sub_b;
            st_d.frame = nxt_frame;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= CELL_W'(CELLS - 1);
            st_q.sub_b <= 1'b1;
            st_q.frame <= FW'(BLOCK_FRAMES - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    // R6
    frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.frame < FW'(BLOCK_FRAMES));
endmodule

// File: rtl/spdif_tx_frame.sv
`timescale 1ns/1ps
module spdif_tx_frame
    import spdif_tx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int CS_BITS  = 40,
    parameter int FW       = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch,
    input  logic                 nxt_sub_b,
    input  logic [FW-1:0]        nxt_frame,
    input  logic                 s_valid,
    input  logic [SAMPLE_W-1:0]  s_left,
    input  logic [SAMPLE_W-1:0]  s_right,
    input  logic [2:0]           bits_l,
    input  logic [2:0]           bits_r,
    input  logic                 cs_load,
    input  logic [CS_BITS-1:0]   cs_a,
    input  logic [CS_BITS-1:0]   cs_b,
    input  logic                 vld_a,
    input  logic                 vld_b,
    input  logic                 per_sample,
    input  logic                 mute,
    input  logic                 mono_en,
    input  logic                 mono_sel,
    output pre_e                 pre,
    output logic [PAYLOAD_W-1:0] payload,
    output logic                 underrun
);
    localparam int PAD = AUDIO_W - SAMPLE_W;
    localparam int CSW = $clog2(CS_BITS);

    // bits_* order: {user, validity, status}
    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic [2:0]          bl;
        logic [2:0]          br;
        logic [CS_BITS-1:0]  csa;
        logic [CS_BITS-1:0]  csb;
        logic                und;
    } hold_t;

    hold_t h_q, h_d;
    logic                sel_r;
    logic [SAMPLE_W-1:0] smp;
    logic [2:0]          sbits;
    logic [AUDIO_W-1:0]  a24;
    logic [CS_BITS-1:0]  cs_sel;
    logic                v_bit, u_bit, c_bit;

    always_comb begin
        h_d = h_q;
        if (fetch) begin
            if (s_valid) begin
                h_d.left  = s_left;
                h_d.right = s_right;
                h_d.bl    = bits_l;
                h_d.br    = bits_r;
                h_d.und   = 1'b0;
            end else begin
                h_d.und   = 1'b1;
            end
        end
        if (cs_load) begin
            h_d.csa = cs_a;
            h_d.csb = cs_b;
        end

        sel_r  = mono_en ? mono_sel : nxt_sub_b;
        smp    = sel_r ? h_d.right : h_d.left;
        sbits  = sel_r ? h_d.br : h_d.bl;
        a24    = mute ? '0 : (AUDIO_W'(smp) << PAD);
        cs_sel = nxt_sub_b ? h_q.csb : h_q.csa;
        if (per_sample) begin
            u_bit = sbits[2];
            v_bit = sbits[1];
            c_bit = sbits[0];
        end else begin
            u_bit = 1'b0;
            v_bit = nxt_sub_b ? vld_b : vld_a;
            c_bit = (nxt_frame < FW'(CS_BITS)) ? cs_sel[nxt_frame[CSW-1:0]] : 1'b0;
        end
        payload = {^{c_bit, u_bit, v_bit, a24}, c_bit, u_bit, v_bit, a24};
        if (nxt_sub_b)             pre = PRE_W;
        else if (nxt_frame == '0)  pre = PRE_B;
        else                       pre = PRE_M;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign underrun = h_q.und;

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fetch) |-> $stable(h_q.left) && $stable(h_q.right));

    // R12
    underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h_q.und) |-> $past(fetch && !s_valid));
endmodule

// File: rtl/spdif_tx_bmc.sv
`timescale 1ns/1ps
module spdif_tx_bmc
    import spdif_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cell_en,
    input  logic                 boundary,
    input  logic [CELL_W-1:0]    cnt,
    input  pre_e                 pre,
    input  logic [PAYLOAD_W-1:0] payload,
    output logic                 sdo
);
    typedef struct packed {
        logic [PAYLOAD_W-1:0] word;
        logic [7:0]           pat;
        logic                 sdo;
    } enc_t;

    enc_t e_q, e_d;
    logic [CELL_W-1:0] idx;
    logic [4:0]        woff;
    logic              bit_v;

    always_comb begin
        e_d   = e_q;
        idx   = cnt + 1'b1;
        woff  = idx[CELL_W-1:1] - 5'd4;
        bit_v = e_q.word[woff];
        if (boundary) begin
            e_d.word = payload;
            e_d.pat  = pre_pattern(pre) ^ {8{e_q.sdo}};
            e_d.sdo  = e_d.pat[7];
        end else if (cell_en) begin
            if (idx < CELL_W'(8))
                e_d.sdo = e_q.pat[3'd7 - idx[2:0]];
            else if (!idx[0] || bit_v)
                e_d.sdo = ~e_q.sdo;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign sdo = e_q.sdo;

    // R4
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cell_en) |-> $stable(e_q.sdo));

    // R5
    word_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (^e_q.word) == 1'b0);
endmodule

// File: rtl/spdif_tx.sv
`timescale 1ns/1ps
module spdif_tx
    import spdif_tx_pkg::*;
#(
    parameter int SAMPLE_W     = 24,
    parameter int CS_BITS      = 40,
    parameter int BLOCK_FRAMES = 192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cell_en,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    input  logic                s_ubit_l,
    input  logic                s_vbit_l,
    input  logic                s_cbit_l,
    input  logic                s_ubit_r,
    input  logic                s_vbit_r,
    input  logic                s_cbit_r,
    input  logic                cs_load,
    input  logic [CS_BITS-1:0]  cs_a,
    input  logic [CS_BITS-1:0]  cs_b,
    input  logic                vld_a,
    input  logic                vld_b,
    input  logic                per_sample,
    input  logic                mute,
    input  logic                mono_en,
    input  logic                mono_sel,
    output logic                sdo,
    output logic                underrun
);
    localparam int FW = $clog2(BLOCK_FRAMES);

    logic [CELL_W-1:0]    cnt;
    logic                 boundary, nxt_sub_b, fetch;
    logic [FW-1:0]        nxt_frame;
    pre_e                 pre;
    logic [PAYLOAD_W-1:0] payload;

    spdif_tx_seq #(.BLOCK_FRAMES(BLOCK_FRAMES), .FW(FW)) u_seq (
        .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .mono_en(mono_en),
        .cnt(cnt), .boundary(boundary), .nxt_sub_b(nxt_sub_b),
        .nxt_frame(nxt_frame), .fetch(fetch)
    );

    spdif_tx_frame #(.SAMPLE_W(SAMPLE_W), .CS_BITS(CS_BITS), .FW(FW)) u_frame (
        .clk(clk), .rst_n(rst_n), .fetch(fetch), .nxt_sub_b(nxt_sub_b),
        .nxt_frame(nxt_frame), .s_valid(s_valid), .s_left(s_left), .s_right(s_right),
        .bits_l({s_ubit_l, s_vbit_l, s_cbit_l}), .bits_r({s_ubit_r, s_vbit_r, s_cbit_r}),
        .cs_load(cs_load), .cs_a(cs_a), .cs_b(cs_b), .vld_a(vld_a), .vld_b(vld_b),
        .per_sample(per_sample), .mute(mute), .mono_en(mono_en), .mono_sel(mono_sel),
        .pre(pre), .payload(payload), .underrun(underrun)
    );

    spdif_tx_bmc u_bmc (
        .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .boundary(boundary),
        .cnt(cnt), .pre(pre), .payload(payload), .sdo(sdo)
    );

    assign s_ready = fetch;
endmodule

// File: tb/sim_spdif_tx.sv
`timescale 1ns/100ps
module sim_spdif_tx;
    localparam int SW = 24;
    localparam int CB = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cell_en = 1'b0, s_valid = 1'b0;
    logic s_ready;
    logic [SW-1:0] s_left = '0, s_right = '0;
    logic ul = 0, vl = 0, cl = 0, ur = 0, vr = 0, cr = 0;
    logic cs_load = 1'b0;
    logic [CB-1:0] cs_a = '0, cs_b = '0;
    logic vld_a = 0, vld_b = 0, per_sample = 0, mute = 0, mono_en = 0, mono_sel = 0;
    logic sdo, underrun;

    always #2.5 clk = ~clk;

    spdif_tx u0 (
        .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .s_valid(s_valid), .s_ready(s_ready),
        .s_left(s_left), .s_right(s_right), .s_ubit_l(ul), .s_vbit_l(vl), .s_cbit_l(cl),
        .s_ubit_r(ur), .s_vbit_r(vr), .s_cbit_r(cr), .cs_load(cs_load), .cs_a(cs_a),
        .cs_b(cs_b), .vld_a(vld_a), .vld_b(vld_b), .per_sample(per_sample), .mute(mute),
        .mono_en(mono_en), .mono_sel(mono_sel), .sdo(sdo), .underrun(underrun)
    );

    int n_chk = 0, n_bad = 0;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_pre(input int kind, input logic prev);
        logic [7:0] p;
        p = (kind == 0) ? 8'hE8 : (kind == 1) ? 8'hE2 : 8'hE4;
        return prev ? ~p : p;
    endfunction

    function automatic logic even_fill(input logic [26:0] f);
        int ones = 0;
        for (int i = 0; i < 27; i++) if (f[i]) ones++;
        return (ones % 2) == 1;
    endfunction

    // bench model
    int bcnt = 63, bframe = 191, efcnt = 0;
    logic bsub = 1'b1, bund = 1'b0;
    logic [SW-1:0] hl = '0, hr = '0;
    logic [2:0] hbl = '0, hbr = '0;   // {u, v, c}
    logic [CB-1:0] bcs_a = '0, bcs_b = '0;
    int   ring_kind [4];
    logic [27:0] ring_pay [4];
    int esf = 0, dsf = 0, cc = 0;
    logic [63:0] cells;
    logic lastlvl = 1'b0;

    task automatic decode_sub();
        logic [7:0] got_pre;
        logic [27:0] got;
        logic ok;
        int k;
        k = dsf % 4;
        for (int i = 0; i < 8; i++) got_pre[7 - i] = cells[i];
        check("R3", "preamble", {24'd0, got_pre}, {24'd0, exp_pre(ring_kind[k], lastlvl)});
        ok = 1'b1;
        for (int s = 4; s < 32; s++) begin
            if (cells[2*s] == cells[2*s - 1]) ok = 1'b0;
            got[s - 4] = cells[2*s] ^ cells[2*s + 1];
        end
        check("R4", "slot edge", {31'd0, ok}, 32'd1);
        check("R2/R9/R10", "audio", {8'd0, got[23:0]}, {8'd0, ring_pay[k][23:0]});
        check("R7/R8", "validity", {31'd0, got[24]}, {31'd0, ring_pay[k][24]});
        check("R7/R8", "user", {31'd0, got[25]}, {31'd0, ring_pay[k][25]});
        check("R6/R8", "status", {31'd0, got[26]}, {31'd0, ring_pay[k][26]});
        check("R5", "parity", {31'd0, got[27]}, {31'd0, ring_pay[k][27]});
        lastlvl = cells[63];
        dsf++;
    endtask

    initial begin
        logic prev_ce, prev_bnd, bnd, nsub, fetch_e, ch, early_load;
        logic [SW-1:0] smp;
        logic [2:0] sb;
        logic [23:0] a;
        logic v, u, c;
        int nframe, cyc, kind, vprob;
        void'($urandom(32'h5D1F));
        prev_ce = 0; prev_bnd = 0; cyc = 0; early_load = 0;

        // R1: reset state and quiet period before the first cell enable
        repeat (4) begin
            @(negedge clk);
            check("R1", "sdo in reset", {31'd0, sdo}, 32'd0);
            check("R1", "ready in reset", {31'd0, s_ready}, 32'd0);
        end
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R1", "sdo idle", {31'd0, sdo}, 32'd0);
            check("R1", "ready idle", {31'd0, s_ready}, 32'd0);
            check("R1", "underrun idle", {31'd0, underrun}, 32'd0);
        end

        while (efcnt < 450) begin
            @(negedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_chk++; n_bad++;
                $display("FAIL R11 watchdog actual=%0d expected<190000", cyc);
                break;
            end
            if (prev_ce) begin
                cells[cc] = sdo;
                cc++;
                if (cc == 64) begin
                    cc = 0;
                    decode_sub();
                end
            end
            if (prev_bnd) check("R12", "underrun flag", {31'd0, underrun}, {31'd0, bund});

            // stimulus
            cell_en = ($urandom % 2) == 0;
            vprob   = (efcnt >= 420) ? 30 : 85;
            s_valid = ($urandom % 100) < vprob;
            s_left  = SW'($urandom); s_right = SW'($urandom);
            {ul, vl, cl, ur, vr, cr} = 6'($urandom);
            vld_a = $urandom % 2; vld_b = $urandom % 2;
            mute       = (efcnt >= 200 && efcnt < 260);
            per_sample = (efcnt >= 260 && efcnt < 340) || (efcnt >= 360 && efcnt < 380);
            mono_en    = (efcnt >= 340 && efcnt < 420);
            mono_sel   = (efcnt >= 380);
            cs_load = 1'b0;
            if (cyc == 1 || (efcnt == 100 && !early_load)) begin
                cs_load = 1'b1;
                cs_a = {8'($urandom), 32'($urandom)};
                cs_b = {8'($urandom), 32'($urandom)};
                if (efcnt == 100) early_load = 1'b1;
            end
            #0.5;

            // model of the coming clock edge
            bnd = cell_en && (bcnt == 63);
            fetch_e = 1'b0;
            if (bnd) begin
                nsub = ~bsub;
                nframe = nsub ? bframe : (bframe + 1) % 192;
                fetch_e = mono_en || !nsub;
                if (fetch_e) begin
                    if (s_valid) begin
                        hl = s_left; hr = s_right;
                        hbl = {ul, vl, cl}; hbr = {ur, vr, cr};
                        bund = 1'b0;
                    end else bund = 1'b1;
                end
                ch  = mono_en ? mono_sel : nsub;
                smp = ch ? hr : hl;
                sb  = ch ? hbr : hbl;
                a   = mute ? 24'd0 : 24'(smp);
                if (per_sample) begin
                    u = sb[2]; v = sb[1]; c = sb[0];
                end else begin
                    u = 1'b0;
                    v = nsub ? vld_b : vld_a;
                    c = (nframe < CB) ? (nsub ? bcs_b[nframe] : bcs_a[nframe]) : 1'b0;
                end
                kind = nsub ? 2 : ((nframe == 0) ? 0 : 1);
                ring_kind[esf % 4] = kind;
                ring_pay[esf % 4]  = {even_fill({c, u, v, a}), c, u, v, a};
                esf++;
                if (!nsub) efcnt++;
                bsub = nsub; bframe = nframe;
            end
            if (cell_en) bcnt = (bcnt + 1) % 64;
            if (cs_load) begin bcs_a = cs_a; bcs_b = cs_b; end
            // R11: ready only at a fetch boundary
            check("R11", "s_ready", {31'd0, s_ready}, {31'd0, bnd && fetch_e});
            prev_ce = cell_en; prev_bnd = bnd;
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule